// File: doc/BRIEF.md
# Phase Resync Timer Controller

This block is the digital sequencer in a fractional-N synthesizer that decides when the output phase is realigned to the reference after a frequency change. It runs on the phase-detector clock. Two cascaded counters form a periodic sync tick. A prescaler counts the effective modulus, and a second counter counts the effective clock-divider value, so one tick period is the product of the two. The tick runs at all times because other timing functions, such as fast lock, share it.

When a write of the frequency register completes, the block restarts both counters and, unless band selection is disabled, raises a one-cycle band-select request. If resync is also enabled, the sequencer arms itself, waits for the chip-select rising edge, counts two sync ticks that come strictly after that edge, and then emits a one-cycle resync strobe. A further frequency write before the strobe cancels the pending resync and starts over.

The sequencer has five states. `ST_IDLE` waits for a frequency write. `ST_WAIT_CS` is armed and waits for the chip-select edge. `ST_WAIT_T1` waits for the first tick after that edge. `ST_WAIT_T2` waits for the second tick. `ST_FIRE` drives the strobe for one cycle. The transitions are as follows:
- A frequency write from any state goes to `ST_WAIT_CS` when resync is permitted, and to `ST_IDLE` otherwise.
- `ST_WAIT_CS` moves to `ST_WAIT_T1` on the chip-select edge.
- `ST_WAIT_T1` moves to `ST_WAIT_T2` on a tick.
- `ST_WAIT_T2` moves to `ST_FIRE` on a tick.
- `ST_FIRE` always returns to `ST_IDLE`.

Top module: `phase_resync_ctrl`

## Requirements
- R1: After a frequency write sampled at clock edge E0, `sync_tick_o` is high in cycle n after E0 exactly when n is a multiple of P = Meff × Deff. Cycle 1 is the cycle right after E0.
- R2: When `ext_phase_i` is 1, Meff is min(`mod_i`, 4095). When it is 0, Meff is `mod_i`.
- R3: A `clkdiv_i` of 0 acts as 1, and a `mod_i` of 0 acts as 1, so ticks never stop.
- R4: With `band_sel_dis_i` = 0, a frequency write gives `band_sel_req_o` high for exactly cycle 1.
- R5: With `band_sel_dis_i` = 1, a frequency write gives neither a band-select request nor a resync strobe.
- R6: Resync is permitted only when `resync_mode_i` equals 2'b10. The values 2'b00, 2'b01 and 2'b11 give no strobe.
- R7: When armed, `resync_o` is high for exactly one cycle. That cycle follows the second tick that falls in a cycle strictly after the cycle in which `cs_rise_i` was high. A tick in the same cycle as the chip-select edge does not count.
- R8: A frequency write that arrives before the strobe cancels the pending resync.
- R9: Ticks continue whether or not a resync is armed, including when band selection is disabled.
- R10: After reset, `band_sel_req_o` and `resync_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clkdiv_i | input | 12 | Clock-divider count for the tick timer |
| mod_i | input | 16 | Fractional modulus |
| ext_phase_i | input | 1 | Wide-phase mode, clamps the modulus to 4095 |
| resync_mode_i | input | 2 | Resync mode field, 2'b10 enables resync |
| band_sel_dis_i | input | 1 | Suppresses band selection and resync |
| freq_wr_i | input | 1 | One-cycle pulse when a frequency-register write completes |
| cs_rise_i | input | 1 | One-cycle pulse on the chip-select rising edge |
| band_sel_req_o | output | 1 | One-cycle VCO band-selection request |
| resync_o | output | 1 | One-cycle phase resync strobe |
| sync_tick_o | output | 1 | Raw periodic sync tick |

## Verification
The bench puts the chip-select edge in the same cycle as a tick. A design that counted that tick would fire one tick period early. A modulus above 4095 is run with and without wide-phase mode, so a missing or always-on clamp shows up as the wrong tick period. A zero clock-divider count and a zero modulus would stall a naive timer, and the bench would see no ticks. Each non-10 mode value and the band-select disable are shown to suppress the strobe while ticks keep running. A second write is issued mid-wait, so a design that kept its old arm state would emit a stray strobe, and a design that did not restart its counters would show a shifted tick phase.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT_CS = 3'd1,
        ST_WAIT_T1 = 3'd2,
        ST_WAIT_T2 = 3'd3,
        ST_FIRE    = 3'd4
    } prc_state_t;

    localparam logic [1:0] RESYNC_ON = 2'b10;

endpackage

// File: rtl/prc_operands.sv
module prc_operands #(
    parameter int MOD_W   = 16,
    parameter int DIV_W   = 12,
    parameter int MOD_CAP = 4095
) (
    input  logic [MOD_W-1:0] mod_raw,
    input  logic [DIV_W-1:0] div_raw,
    input  logic             ext_phase,
    output logic [MOD_W-1:0] mod_eff,
    output logic [DIV_W-1:0] div_eff
);
    localparam logic [MOD_W-1:0] CAP = MOD_W'(MOD_CAP);

    logic [MOD_W-1:0] mod_clamped;

    always_comb begin
        if (ext_phase && (mod_raw > CAP)) begin
            mod_clamped = CAP;
        end else begin
            mod_clamped = mod_raw;
        end
        mod_eff = (mod_clamped == '0) ? MOD_W'(1) : mod_clamped;
        div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
    end

endmodule

// File: rtl/prc_prescaler.sv
module prc_prescaler #(
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [MOD_W-1:0] mod_eff,
    output logic             pre_tick
);
    logic [MOD_W-1:0] pcnt;

    assign pre_tick = (pcnt >= (mod_eff - MOD_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (restart || pre_tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + MOD_W'(1);
        end
    end

    p_restart_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pcnt == '0));

endmodule

// File: rtl/prc_tick_counter.sv
module prc_tick_counter #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             pre_tick,
    input  logic [DIV_W-1:0] div_eff,
    output logic             sync_tick
);
    logic [DIV_W-1:0] tcnt;
    logic             last;

    assign last      = (tcnt >= (div_eff - DIV_W'(1)));
    assign sync_tick = pre_tick && last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt <= '0;
        end else if (restart) begin
            tcnt <= '0;
        end else if (pre_tick) begin
            tcnt <= last ? '0 : tcnt + DIV_W'(1);
        end
    end

    p_tick_needs_pre_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_tick |-> pre_tick);
    p_restart_tcnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tcnt == '0));

endmodule

// File: rtl/prc_seq_fsm.sv
module prc_seq_fsm
    import prc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       freq_wr,
    input  logic       cs_rise,
    input  logic       sync_tick,
    input  logic [1:0] mode,
    input  logic       band_dis,
    output logic       band_req,
    output logic       resync
);
    prc_state_t state, state_nx;
    logic       arm_ok;
    logic       req_q;

    assign arm_ok = !band_dis && (mode == RESYNC_ON);

    always_comb begin
        state_nx = state;
        if (freq_wr) begin
            state_nx = arm_ok ? ST_WAIT_CS : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_WAIT_CS: if (cs_rise)   state_nx = ST_WAIT_T1;
                ST_WAIT_T1: if (sync_tick) state_nx = ST_WAIT_T2;
                ST_WAIT_T2: if (sync_tick) state_nx = ST_FIRE;
                ST_FIRE:    state_nx = ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else begin
            req_q <= freq_wr && !band_dis;
        end
    end

    assign band_req = req_q;
    assign resync   = (state == ST_FIRE);

    p_req_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        band_req && !$past(freq_wr) |-> 1'b0 || band_req == 1'b0 || $past(freq_wr));
    p_req_after_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_wr && !band_dis) |=> band_req);
    p_dis_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_wr && band_dis) |=> !band_req);
    p_mode_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_wr && (mode != RESYNC_ON)) |=> (state == ST_IDLE));
    p_resync_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> !resync);
    p_resync_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $past(sync_tick));
    p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freq_wr |=> !resync);

endmodule

// File: rtl/phase_resync_ctrl.sv
module phase_resync_ctrl #(
    parameter int MOD_W   = 16,
    parameter int DIV_W   = 12,
    parameter int MOD_CAP = 4095
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] clkdiv_i,
    input  logic [MOD_W-1:0] mod_i,
    input  logic             ext_phase_i,
    input  logic [1:0]       resync_mode_i,
    input  logic             band_sel_dis_i,
    input  logic             freq_wr_i,
    input  logic             cs_rise_i,
    output logic             band_sel_req_o,
    output logic             resync_o,
    output logic             sync_tick_o
);
    logic [MOD_W-1:0] mod_eff;
    logic [DIV_W-1:0] div_eff;
    logic             pre_tick;
    logic             sync_tick;

    prc_operands #(.MOD_W(MOD_W), .DIV_W(DIV_W), .MOD_CAP(MOD_CAP)) u_ops (
        .mod_raw   (mod_i),
        .div_raw   (clkdiv_i),
        .ext_phase (ext_phase_i),
        .mod_eff   (mod_eff),
        .div_eff   (div_eff)
    );

    prc_prescaler #(.MOD_W(MOD_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (freq_wr_i),
        .mod_eff  (mod_eff),
        .pre_tick (pre_tick)
    );

    prc_tick_counter #(.DIV_W(DIV_W)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (freq_wr_i),
        .pre_tick  (pre_tick),
        .div_eff   (div_eff),
        .sync_tick (sync_tick)
    );

    prc_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_wr   (freq_wr_i),
        .cs_rise   (cs_rise_i),
        .sync_tick (sync_tick),
        .mode      (resync_mode_i),
        .band_dis  (band_sel_dis_i),
        .band_req  (band_sel_req_o),
        .resync    (resync_o)
    );

    assign sync_tick_o = sync_tick;

endmodule

// File: tb/test_phase_resync_ctrl.sv
module test_phase_resync_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] clkdiv_i = '0;
    logic [15:0] mod_i = 16'd3;
    logic        ext_phase_i = 1'b0;
    logic [1:0]  resync_mode_i = 2'b00;
    logic        band_sel_dis_i = 1'b0;
    logic        freq_wr_i = 1'b0;
    logic        cs_rise_i = 1'b0;
    logic        band_sel_req_o, resync_o, sync_tick_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    phase_resync_ctrl i_phase_resync_ctrl (
        .clk(clk), .rst_n(rst_n), .clkdiv_i(clkdiv_i), .mod_i(mod_i),
        .ext_phase_i(ext_phase_i), .resync_mode_i(resync_mode_i),
        .band_sel_dis_i(band_sel_dis_i), .freq_wr_i(freq_wr_i),
        .cs_rise_i(cs_rise_i), .band_sel_req_o(band_sel_req_o),
        .resync_o(resync_o), .sync_tick_o(sync_tick_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // One scenario: frequency write, optional chip-select edge at cycle c (0 = none),
    // observe n cycles and compare every cycle against independently computed values.
    task automatic run_case(input int m, input int d, input bit ext, input bit [1:0] mode,
                            input bit dis, input int c, input int n,
                            input string t_tag, input string q_tag, input string s_tag);
        int meff, deff, p, t2, fire;
        int bad_t, bad_q, bad_s;
        bit armed;
        meff = (ext && m > 4095) ? 4095 : m;
        if (meff == 0) meff = 1;
        deff = (d == 0) ? 1 : d;
        p = meff * deff;
        armed = !dis && (mode == 2'b10) && (c > 0);
        t2 = (c / p + 2) * p;
        fire = armed ? t2 + 1 : -1;
        bad_t = 0; bad_q = 0; bad_s = 0;
        mod_i = 16'(m); clkdiv_i = 12'(d); ext_phase_i = ext;
        resync_mode_i = mode; band_sel_dis_i = dis;
        freq_wr_i = 1'b1;
        @(negedge clk);
        freq_wr_i = 1'b0;
        for (int cyc = 1; cyc <= n; cyc++) begin
            if (sync_tick_o !== ((cyc % p) == 0)) begin
                if (bad_t == 0)
                    $display("FAIL %s tick at cycle %0d: actual %0b expected %0b",
                             t_tag, cyc, sync_tick_o, (cyc % p) == 0);
                bad_t++;
            end
            if (band_sel_req_o !== (!dis && cyc == 1)) begin
                if (bad_q == 0)
                    $display("FAIL %s band request at cycle %0d: actual %0b expected %0b",
                             q_tag, cyc, band_sel_req_o, (!dis && cyc == 1));
                bad_q++;
            end
            if (resync_o !== (cyc == fire)) begin
                if (bad_s == 0)
                    $display("FAIL %s resync at cycle %0d: actual %0b expected %0b",
                             s_tag, cyc, resync_o, (cyc == fire));
                bad_s++;
            end
            cs_rise_i = (cyc == c);
            @(negedge clk);
        end
        cs_rise_i = 1'b0;
        tests += 3;
        fails += (bad_t != 0) + (bad_q != 0) + (bad_s != 0);
    endtask

    task automatic check_reset();
        for (int i = 0; i < 4; i++) begin
            tests++;
            if (band_sel_req_o !== 1'b0 || resync_o !== 1'b0) begin
                fails++;
                $display("FAIL R10 reset outputs: actual req=%0b resync=%0b expected 0 0",
                         band_sel_req_o, resync_o);
            end
            @(negedge clk);
        end
    endtask

    task automatic cancel_case();
        // R8: arm, chip-select edge, then a new write before the strobe is due
        run_case(4, 2, 1'b0, 2'b10, 1'b0, 2, 5, "R1", "R4", "R8");
        run_case(4, 2, 1'b0, 2'b10, 1'b0, 0, 30, "R1", "R4", "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset();
        run_case(3, 2, 1'b0, 2'b10, 1'b0, 2, 20, "R1", "R4", "R7");
        run_case(5, 1, 1'b0, 2'b10, 1'b0, 5, 22, "R1", "R4", "R7");
        run_case(7, 3, 1'b0, 2'b10, 1'b0, 1, 50, "R1", "R4", "R7");
        run_case(5000, 1, 1'b1, 2'b10, 1'b0, 10, 8200, "R2", "R4", "R7");
        run_case(5000, 1, 1'b0, 2'b10, 1'b0, 10, 10005, "R2", "R4", "R7");
        run_case(100, 2, 1'b1, 2'b10, 1'b0, 3, 420, "R2", "R4", "R7");
        run_case(4, 0, 1'b0, 2'b10, 1'b0, 3, 12, "R3", "R4", "R7");
        run_case(0, 3, 1'b0, 2'b10, 1'b0, 1, 12, "R3", "R4", "R7");
        run_case(3, 1, 1'b0, 2'b11, 1'b0, 2, 12, "R9", "R4", "R6");
        run_case(3, 1, 1'b0, 2'b01, 1'b0, 2, 12, "R9", "R4", "R6");
        run_case(3, 1, 1'b0, 2'b00, 1'b0, 2, 12, "R9", "R4", "R6");
        run_case(3, 2, 1'b0, 2'b10, 1'b1, 2, 20, "R9", "R5", "R5");
        cancel_case();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule